// File: doc/BRIEF.md
# Double-Buffered Parallel Converter Code Front End

This block sits between a microcontroller-style parallel bus and a 12-bit converter core. A host writes a word into a staging register under chip-select and read/write control, and it can read that staging register back over the same bus. A second register feeds the converter code. It behaves as a level-sensitive latch: while the load strobe is low it follows the staging register, and while the strobe is high it holds. The staging register can therefore be rewritten without disturbing the code in use. An active-low clear forces the converter code to zero at once, and it keeps the code at zero until a load strobe copies the staging register again.

All pins are sampled into a system clock domain through a flop chain of `SYNC_STAGES` stages. The latch is modelled as a per-cycle update, so the design is fully synchronous apart from the clear. The clear asserts asynchronously and is released in step with the clock. The bus appears as separate in, out and drive-enable signals, and the pad-level tri-state buffer lives outside the block. A one-cycle flag marks every change of the converter code value.

Top module: `dac_parallel_frontend`

## Requirements
- R1: When chip select is low (`cs_n`=0) and `rw`=0, the staging register captures `bus_in`. In every other pin state it keeps its value.
- R2: When `cs_n`=0 and `rw`=1, `bus_oe` is 1 and `bus_out` carries the staging register. In every other state `bus_oe` is 0 and `bus_out` is 0. A read does not alter the staging register.
- R3: While `load_n`=0 the converter code follows the staging register, whatever the state of `cs_n`. While `load_n`=1 the converter code holds.
- R4: Driving `clr_n` low forces `dac_code` to 000h without waiting for a clock edge. `clr_n` does not touch the staging register.
- R5: After `clr_n` returns high, `dac_code` stays at 000h while `load_n`=1. If `load_n` is low, or later goes low, the code picks up the staging register again.
- R6: The code is 12-bit straight binary with bit 11 as MSB. 000h is zero scale, 800h is midscale (only bit 11 set), 7FFh is one step below midscale and FFFh is full scale. `dac_code` equals the written word bit for bit.
- R7: While `load_n`=0 during an open write (`cs_n`=0, `rw`=0), every new `bus_in` word reaches `dac_code`. Once `cs_n` is high, further bus changes do not reach it.
- R8: After `rst_n` has been low, the staging register, `dac_code`, `bus_oe` and `code_changed` are all zero, so a readback returns 000h.
- R9: `code_changed` is high for exactly the one cycle after each clock edge at which the value of `dac_code` changes. While the code holds, it stays low.
- R10: Latency with `SYNC_STAGES`=2, counting rising edges after the pins change: `bus_oe` rises at the 2nd edge. For a write with `load_n` already low, `dac_code` changes at the 4th edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read back the staging register, 0 = write it |
| load_n | input | 1 | Load strobe, active low; the code register is transparent while it is low |
| clr_n | input | 1 | Clear of the converter code, active low, asynchronous assert |
| bus_in | input | 12 | Word arriving from the data bus |
| bus_out | output | 12 | Readback word for the bus pad driver |
| bus_oe | output | 1 | Drive enable for the bus pad driver |
| dac_code | output | 12 | Straight-binary code feeding the converter core |
| code_changed | output | 1 | One-cycle flag after each change of `dac_code` |

## Verification
The bench targets the double-buffer separation. A write with the strobe high must leave the code alone while the readback already shows the new word; a design that wired the latch to the bus instead of the staging register would move the code early. It drives the clear while the strobe is high and again while it is low, and checks the zero between clock edges. A design that cleared synchronously, or that reloaded on clear release regardless of the strobe, would show a stale or premature code. It also counts edges exactly for the readback enable and the code update, and it moves the bus before and after chip select closes, so that a wrong pipeline depth or a latch that ignores chip-select closure shows up as a mismatch.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  localparam int unsigned CODE_W_DEFAULT = 12;
  localparam int unsigned SYNC_DEFAULT   = 2;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_WRITE = 2'd1,
    BUS_READ  = 2'd2
  } bus_op_e;

  function automatic bus_op_e decode_op(input logic cs_n, input logic rw);
    if (cs_n)    return BUS_IDLE;
    else if (rw) return BUS_READ;
    else         return BUS_WRITE;
  endfunction

endpackage

// File: rtl/dacfe_rst_sync.sv
module dacfe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[0] <= 1'b0;
          else         chain_q[0] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/dacfe_pin_sync.sv
module dacfe_pin_sync #(
  parameter int unsigned        W       = 15,
  parameter int unsigned        STAGES  = 2,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] pins_s
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic [W-1:0] stage_d;
      if (i == 0) begin : g_src_pin
        assign stage_d = pins;
      end else begin : g_src_prev
        assign stage_d = stage_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= RST_VAL;
        else        stage_q[i] <= stage_d;
      end
    end
  endgenerate

  assign pins_s = stage_q[STAGES-1];

endmodule

// File: rtl/dacfe_input_reg.sv
module dacfe_input_reg
  import dacfe_pkg::*;
#(
  parameter int unsigned CODE_W = CODE_W_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_op_e           op,
  input  logic [CODE_W-1:0] bus_d,
  output logic [CODE_W-1:0] stage_q,
  output logic              bus_oe,
  output logic [CODE_W-1:0] bus_out
);

  logic              wr_en;
  logic [CODE_W-1:0] stage_d;

  always_comb begin
    wr_en   = (op == BUS_WRITE);
    stage_d = stage_q;
    if (wr_en) stage_d = bus_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  always_comb begin
    bus_oe  = (op == BUS_READ);
    bus_out = bus_oe ? stage_q : '0;
  end

  AST_WRITE_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (stage_q == $past(bus_d))); // R1

  AST_READ_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |=> $stable(stage_q)); // R2

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !bus_oe); // R2

endmodule

// File: rtl/dacfe_code_latch.sv
module dacfe_code_latch
  import dacfe_pkg::*;
#(
  parameter int unsigned CODE_W = CODE_W_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_rst_n,
  input  logic              load_n_s,
  input  logic [CODE_W-1:0] stage_q,
  output logic [CODE_W-1:0] code_q,
  output logic              code_changed
);

  logic [CODE_W-1:0] code_d;
  logic              load_en;
  logic [CODE_W-1:0] prev_q;

  always_comb begin
    load_en = !load_n_s;
    code_d  = code_q;
    if (load_en) code_d = stage_q;
  end

  always_ff @(posedge clk or negedge clr_rst_n) begin
    if (!clr_rst_n) code_q <= '0;
    else            code_q <= code_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= code_q;
  end

  assign code_changed = (prev_q != code_q);

  AST_FOLLOW_WHEN_OPEN: assert property (@(posedge clk) disable iff (!clr_rst_n)
    !load_n_s |=> (code_q == $past(stage_q))); // R3

  AST_HOLD_WHEN_SHUT: assert property (@(posedge clk) disable iff (!clr_rst_n)
    load_n_s |=> $stable(code_q)); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_rst_n |-> (code_q == '0)); // R4

  AST_FLAG_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    code_changed |-> (code_q != $past(code_q))); // R9

endmodule

// File: rtl/dac_parallel_frontend.sv
module dac_parallel_frontend
  import dacfe_pkg::*;
#(
  parameter int unsigned CODE_W      = CODE_W_DEFAULT,
  parameter int unsigned SYNC_STAGES = SYNC_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rw,
  input  logic              load_n,
  input  logic              clr_n,
  input  logic [CODE_W-1:0] bus_in,
  output logic [CODE_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [CODE_W-1:0] dac_code,
  output logic              code_changed
);

  localparam int unsigned PIN_W = CODE_W + 3;
  localparam logic [PIN_W-1:0] PIN_IDLE = {3'b111, {CODE_W{1'b0}}};

  logic              sys_rst_n;
  logic              clr_src_n;
  logic              clr_rst_n;
  logic [PIN_W-1:0]  pins_raw;
  logic [PIN_W-1:0]  pins_s;
  logic              cs_n_s;
  logic              rw_s;
  logic              load_n_s;
  logic [CODE_W-1:0] bus_s;
  bus_op_e           op;
  logic [CODE_W-1:0] stage_q;

  dacfe_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (sys_rst_n)
  );

  assign clr_src_n = rst_n & clr_n;

  dacfe_rst_sync #(.STAGES(SYNC_STAGES)) u_clr_rst (
    .clk    (clk),
    .arst_n (clr_src_n),
    .srst_n (clr_rst_n)
  );

  assign pins_raw = {cs_n, rw, load_n, bus_in};

  dacfe_pin_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_pins (
    .clk    (clk),
    .rst_n  (sys_rst_n),
    .pins   (pins_raw),
    .pins_s (pins_s)
  );

  always_comb begin
    cs_n_s   = pins_s[CODE_W+2];
    rw_s     = pins_s[CODE_W+1];
    load_n_s = pins_s[CODE_W];
    bus_s    = pins_s[CODE_W-1:0];
    op       = decode_op(cs_n_s, rw_s);
  end

  dacfe_input_reg #(.CODE_W(CODE_W)) u_stage (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .op      (op),
    .bus_d   (bus_s),
    .stage_q (stage_q),
    .bus_oe  (bus_oe),
    .bus_out (bus_out)
  );

  dacfe_code_latch #(.CODE_W(CODE_W)) u_code (
    .clk          (clk),
    .rst_n        (sys_rst_n),
    .clr_rst_n    (clr_rst_n),
    .load_n_s     (load_n_s),
    .stage_q      (stage_q),
    .code_q       (dac_code),
    .code_changed (code_changed)
  );

  AST_CLEAR_SPARES_STAGE: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!clr_rst_n && op != BUS_WRITE) |=> $stable(stage_q)); // R4

  AST_RESET_IDLE_BUS: assert property (@(posedge clk)
    !sys_rst_n |-> (!bus_oe && stage_q == '0)); // R8

endmodule

// File: tb/sim_dac_parallel_frontend.sv
module sim_dac_parallel_frontend;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, rw, load_n, clr_n;
  logic [11:0] bus_in;
  logic [11:0] bus_out;
  logic        bus_oe;
  logic [11:0] dac_code;
  logic        code_changed;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  dac_parallel_frontend u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .rw           (rw),
    .load_n       (load_n),
    .clr_n        (clr_n),
    .bus_in       (bus_in),
    .bus_out      (bus_out),
    .bus_oe       (bus_oe),
    .dac_code     (dac_code),
    .code_changed (code_changed)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_word(input logic [11:0] w);
    cs_n = 1'b0; rw = 1'b0; bus_in = w;
    step(4);
    cs_n = 1'b1; rw = 1'b1;
    step(4);
  endtask

  task automatic read_word(output logic [11:0] w);
    cs_n = 1'b0; rw = 1'b1;
    step(3);
    w = bus_out;
    cs_n = 1'b1;
    step(3);
  endtask

  task automatic t_reset;
    logic [11:0] rb;
    check("R8", "code after reset", dac_code, 12'h000);
    check("R8", "oe after reset", bus_oe, 1'b0);
    check("R8", "flag after reset", code_changed, 1'b0);
    read_word(rb);
    check("R8", "readback after reset", rb, 12'h000);
  endtask

  task automatic t_latency;
    load_n = 1'b0; step(4);
    cs_n = 1'b0; rw = 1'b0; bus_in = 12'h800;
    step(3);
    check("R10", "code before 4th edge", dac_code, 12'h000);
    step(1);
    check("R10", "code at 4th edge", dac_code, 12'h800);
    check("R9", "flag on change", code_changed, 1'b1);
    step(1);
    check("R9", "flag one cycle only", code_changed, 1'b0);
    cs_n = 1'b1; rw = 1'b1; step(4);
    load_n = 1'b1; step(4);
    cs_n = 1'b0; rw = 1'b1;
    step(1);
    check("R10", "oe before 2nd edge", bus_oe, 1'b0);
    step(1);
    check("R10", "oe at 2nd edge", bus_oe, 1'b1);
    check("R2", "readback word", bus_out, 12'h800);
    cs_n = 1'b1; step(4);
    check("R2", "oe low when idle", bus_oe, 1'b0);
    check("R2", "bus_out zero when idle", bus_out, 12'h000);
  endtask

  task automatic t_double_buffer;
    logic [11:0] rb;
    write_word(12'hABC);
    check("R3", "code held while strobe high", dac_code, 12'h800);
    read_word(rb);
    check("R1", "stage took word", rb, 12'hABC);
    check("R2", "read left stage alone", dac_code, 12'h800);
    read_word(rb);
    check("R2", "second readback", rb, 12'hABC);
    load_n = 1'b0; step(4);
    check("R3", "code follows on strobe", dac_code, 12'hABC);
    load_n = 1'b1; step(4);
    write_word(12'h123);
    check("R3", "strobe high holds old code", dac_code, 12'hABC);
    load_n = 1'b0; step(4);
    check("R3", "follows with chip select high", dac_code, 12'h123);
    load_n = 1'b1; step(4);
  endtask

  task automatic t_hold_no_flag;
    int seen = 0;
    for (int i = 0; i < 10; i++) begin
      step(1);
      if (code_changed) seen++;
    end
    check("R9", "no flag while holding", seen, 0);
  endtask

  task automatic t_transparent;
    load_n = 1'b0; step(4);
    cs_n = 1'b0; rw = 1'b0; bus_in = 12'h111;
    step(4);
    check("R7", "open write first word", dac_code, 12'h111);
    bus_in = 12'h222;
    step(4);
    check("R7", "open write second word", dac_code, 12'h222);
    cs_n = 1'b1; rw = 1'b1;
    step(3);
    bus_in = 12'h333;
    step(4);
    check("R7", "closed write blocks bus", dac_code, 12'h222);
    load_n = 1'b1; step(4);
  endtask

  task automatic t_clear;
    logic [11:0] rb;
    write_word(12'h5A5);
    load_n = 1'b0; step(4); load_n = 1'b1; step(4);
    check("R3", "code before clear", dac_code, 12'h5A5);
    clr_n = 1'b0;
    #1;
    check("R4", "clear acts without edge", dac_code, 12'h000);
    step(3);
    clr_n = 1'b1;
    step(6);
    check("R5", "zero after release, strobe high", dac_code, 12'h000);
    read_word(rb);
    check("R4", "clear spares stage", rb, 12'h5A5);
    load_n = 1'b0; step(4);
    check("R5", "strobe reloads after clear", dac_code, 12'h5A5);
    clr_n = 1'b0;
    #1;
    check("R4", "clear with strobe low", dac_code, 12'h000);
    step(3);
    clr_n = 1'b1;
    step(6);
    check("R5", "follows again after release", dac_code, 12'h5A5);
    load_n = 1'b1; step(4);
  endtask

  task automatic t_scale;
    logic [11:0] codes [4];
    codes[0] = 12'h000; codes[1] = 12'hFFF; codes[2] = 12'h800; codes[3] = 12'h7FF;
    for (int k = 0; k < 4; k++) begin
      write_word(codes[k]);
      load_n = 1'b0; step(4); load_n = 1'b1; step(4);
      check("R6", "scale code", dac_code, codes[k]);
      check("R6", "msb position", dac_code[11], codes[k][11]);
    end
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rw = 1'b1; load_n = 1'b1; clr_n = 1'b1; bus_in = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_latency();
    t_double_buffer();
    t_hold_no_flag();
    t_transparent();
    t_clear();
    t_scale();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

endmodule